// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block performs one add, subtract or bitwise logic operation on two operands, at either byte or word width, and presents the result at once on a combinational output. When an update is requested, it captures the arithmetic status of that result in a flags register on the next clock edge. The status covers carry or borrow, even parity, nibble carry, zero, sign and signed overflow.

The same register also holds three control bits: single-step trap, interrupt enable and string direction. Arithmetic never changes these bits. Trap and direction are loaded by their own write strobes. Interrupt enable has separate set and clear commands. An execution stage drives an operation with its update enable, and later stages read the status bits to decide branches.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is combinational. Op code 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A OR B and 4 gives A XOR B, each taken modulo the width. With `wide`=0 only bits 7:0 of the operands are used and bits 15:8 of `result` are zero.
- R2: After an add, carry (`flags_q[0]`) is set when the unsigned sum exceeds the width, for example byte 0xFF+0x01. After a subtract, carry is set when the unsigned A is less than B (a borrow).
- R3: Overflow (`flags_q[5]`) is set after an add or subtract whose signed result has the wrong sign, for example byte 0x7F+0x01 or byte 0x80-0x01.
- R4: Auxiliary carry (`flags_q[2]`) is set when a carry out of bit 3 occurs on an add, or a borrow into bit 3 occurs on a subtract.
- R5: Zero (`flags_q[3]`) is set when the result at the selected width is zero, for example 3-3.
- R6: Sign (`flags_q[4]`) copies result bit 7 at byte width and result bit 15 at word width.
- R7: Parity (`flags_q[1]`) is set when result bits 7:0 hold an even number of ones. Bits 15:8 never count.
- R8: Op codes 2, 3 and 4 clear carry, overflow and auxiliary carry, and update zero, sign and parity.
- R9: Flags 5:0 load one clock edge after `op_valid`=1 with op code 0 to 4. With `op_valid`=0, or with op codes 5 to 7, they hold.
- R10: Interrupt enable (`flags_q[7]`) is cleared by `int_clr` and set by `int_set`. If both are raised in the same cycle, the clear wins. Operations leave the bit unchanged.
- R11: Trap (`flags_q[6]`) loads `trap_d` when `trap_we` is high. Direction (`flags_q[8]`) loads `dir_d` when `dir_we` is high. Neither bit changes otherwise.
- R12: Active-low reset clears every bit of `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Update enable for flags 5:0 |
| op_code | input | 3 | Operation select (0 add, 1 sub, 2 and, 3 or, 4 xor) |
| wide | input | 1 | 1 selects word width, 0 selects byte width |
| src_a | input | 16 | Operand A (minuend) |
| src_b | input | 16 | Operand B (subtrahend) |
| trap_we | input | 1 | Trap bit write strobe |
| trap_d | input | 1 | Trap bit write value |
| dir_we | input | 1 | Direction bit write strobe |
| dir_d | input | 1 | Direction bit write value |
| int_set | input | 1 | Set interrupt enable |
| int_clr | input | 1 | Clear interrupt enable (wins over set) |
| result | output | 16 | Operation result |
| flags_q | output | 9 | {dir, int_en, trap, ovf, sign, zero, aux, parity, carry} |

## Verification
The only state is the flags register, so any corruption appears on `flags_q` one cycle after the edge that caused it. A wrong carry or overflow at a width boundary shows on the operation's own next cycle. A bit that moves when it should hold shows on the first idle or illegal-op cycle after it. Control bits that arithmetic disturbs stay wrong until the next explicit write, so the checks read them right after operations as well as after writes.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic        wide,
  input  logic [15:0] src_a,
  input  logic [15:0] src_b,
  input  logic        trap_we,
  input  logic        trap_d,
  input  logic        dir_we,
  input  logic        dir_d,
  input  logic        int_set,
  input  logic        int_clr,
  output logic [15:0] result,
  output logic [8:0]  flags_q
);
  logic [15:0] a_m, b_m;
  logic [16:0] sum_x, dif_x;
  logic [5:0]  stat_c;
  logic        is_sub, is_logic, legal;
  logic        a_s, b_s, r_s, cy, aux, ovf;

  assign a_m   = wide ? src_a : {8'h00, src_a[7:0]};
  assign b_m   = wide ? src_b : {8'h00, src_b[7:0]};
  assign sum_x = {1'b0, a_m} + {1'b0, b_m};
  assign dif_x = {1'b0, a_m} - {1'b0, b_m};

  assign is_sub   = (op_code == 3'd1);
  assign is_logic = (op_code == 3'd2) || (op_code == 3'd3) || (op_code == 3'd4);
  assign legal    = (op_code <= 3'd4);

  always_comb begin
    case (op_code)
      3'd0:    result = wide ? sum_x[15:0] : {8'h00, sum_x[7:0]};
      3'd1:    result = wide ? dif_x[15:0] : {8'h00, dif_x[7:0]};
      3'd2:    result = a_m & b_m;
      3'd3:    result = a_m | b_m;
      3'd4:    result = a_m ^ b_m;
      default: result = 16'h0000;
    endcase
  end

  assign a_s = wide ? a_m[15] : a_m[7];
  assign b_s = wide ? b_m[15] : b_m[7];
  assign r_s = wide ? result[15] : result[7];

  assign cy  = is_sub ? (wide ? dif_x[16] : dif_x[8]) : (wide ? sum_x[16] : sum_x[8]);
  assign aux = a_m[4] ^ b_m[4] ^ result[4];
  assign ovf = is_sub ? ((a_s != b_s) && (r_s != a_s)) : ((a_s == b_s) && (r_s != a_s));

  assign stat_c = {ovf & ~is_logic, r_s, (result == 16'h0000),
                   aux & ~is_logic, ~^result[7:0], cy & ~is_logic};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (op_valid && legal) flags_q[5:0] <= stat_c;
      if (trap_we)           flags_q[6]   <= trap_d;
      if (int_clr)           flags_q[7]   <= 1'b0;
      else if (int_set)      flags_q[7]   <= 1'b1;
      if (dir_we)            flags_q[8]   <= dir_d;
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic        trap_we,
  input logic        dir_we,
  input logic        int_set,
  input logic        int_clr,
  input logic [15:0] result,
  input logic [8:0]  flags_q
);
  logic upd;
  assign upd = op_valid && (op_code <= 3'd4);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q[5:0]));

  p_logic_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 3'd2 && op_code <= 3'd4) |=>
      (flags_q[0] == 1'b0 && flags_q[2] == 1'b0 && flags_q[5] == 1'b0));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags_q[3] == ($past(result) == 16'h0000)));

  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags_q[1] == ~^$past(result[7:0])));

  p_int_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_clr |=> !flags_q[7]);

  p_int_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_set && !int_clr) |=> flags_q[7]);

  p_int_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_set && !int_clr) |=> $stable(flags_q[7]));

  p_trap_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_we && !dir_we) |=> ($stable(flags_q[6]) && $stable(flags_q[8])));
endmodule

bind alu_flag_unit alu_flag_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .trap_we(trap_we), .dir_we(dir_we), .int_set(int_set), .int_clr(int_clr),
  .result(result), .flags_q(flags_q)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, wide = 0, trap_we = 0, trap_d = 0, dir_we = 0, dir_d = 0;
  logic int_set = 0, int_clr = 0;
  logic [2:0]  op_code = 0;
  logic [15:0] src_a = 0, src_b = 0;
  logic [15:0] result;
  logic [8:0]  flags_q;

  int n_cmp = 0, n_bad = 0;
  logic [8:0] exp_f = '0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  alu_flag_unit dut_i (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_res(input int op, input bit w, input int a, input int b);
    int m, ua, ub;
    m = w ? 65535 : 255; ua = a & m; ub = b & m;
    case (op)
      0: return (ua + ub) & m;
      1: return (ua - ub) & m;
      2: return ua & ub;
      3: return ua | ub;
      4: return ua ^ ub;
      default: return 0;
    endcase
  endfunction

  function automatic logic [5:0] ref_flags(input int op, input bit w, input int a, input int b);
    int m, ua, ub, r, sh, ones;
    bit c, p, ac, z, s, o, sa, sb;
    m = w ? 65535 : 255; sh = w ? 15 : 7;
    ua = a & m; ub = b & m;
    r = ref_res(op, w, a, b);
    sa = ((ua >> sh) & 1) != 0; sb = ((ub >> sh) & 1) != 0; s = ((r >> sh) & 1) != 0;
    z = (r == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    p = (ones % 2) == 0;
    c = 0; ac = 0; o = 0;
    if (op == 0) begin
      c = (ua + ub) > m; ac = ((ua & 15) + (ub & 15)) > 15; o = (sa == sb) && (s != sa);
    end else if (op == 1) begin
      c = ua < ub; ac = (ua & 15) < (ub & 15); o = (sa != sb) && (s != sa);
    end
    return {o, s, z, ac, p, c};
  endfunction

  task automatic do_op(input string tag, input int op, input bit w, input int a, input int b, input bit v);
    @(negedge clk);
    op_code = op[2:0]; wide = w; src_a = a[15:0]; src_b = b[15:0]; op_valid = v;
    #1;
    check({tag, " result R1"}, result, ref_res(op, w, a, b));
    if (v && op <= 4) exp_f[5:0] = ref_flags(op, w, a, b);
    @(posedge clk); #1;
    op_valid = 0;
    check({tag, " flags R2 R3 R4 R5 R6 R7 R8 R9"}, flags_q, exp_f);
  endtask

  task automatic t_reset;
    check("reset R12", flags_q, 0);
  endtask

  task automatic t_add;
    do_op("add 0xFF+1 byte carry R2", 0, 0, 'hFF, 1, 1);
    do_op("add 0x7F+1 byte overflow R3", 0, 0, 'h7F, 1, 1);
    do_op("add 0x0F+1 aux R4", 0, 0, 'h0F, 1, 1);
    do_op("add byte ignores high R1", 0, 0, 'hAB12, 'hCD34, 1);
    do_op("add 0xFFFF+1 word R2 R5", 0, 1, 'hFFFF, 1, 1);
    do_op("add 0x7FFF+1 word R3 R6", 0, 1, 'h7FFF, 1, 1);
    do_op("add word mixed", 0, 1, 'h1234, 'h0F0F, 1);
  endtask

  task automatic t_sub;
    do_op("sub 3-3 zero R5", 1, 0, 3, 3, 1);
    do_op("sub 0-1 byte borrow R2", 1, 0, 0, 1, 1);
    do_op("sub 0x80-1 byte overflow R3", 1, 0, 'h80, 1, 1);
    do_op("sub 0x10-1 aux borrow R4", 1, 0, 'h10, 1, 1);
    do_op("sub 0x8000-1 word R3", 1, 1, 'h8000, 1, 1);
    do_op("sub 5-9 word borrow R2", 1, 1, 5, 9, 1);
  endtask

  task automatic t_logic;
    do_op("prep carry", 0, 0, 'hFF, 'hFF, 1);
    do_op("and clears R8", 2, 0, 'hF0, 'h3C, 1);
    do_op("prep overflow", 0, 0, 'h7F, 'h7F, 1);
    do_op("or R8 R6", 3, 1, 'h8001, 'h0100, 1);
    do_op("xor zero R8 R5", 4, 1, 'h5A5A, 'h5A5A, 1);
  endtask

  task automatic t_parity;
    do_op("parity low byte only word R7", 3, 1, 'h0300, 'h0001, 1);
    do_op("parity high ones ignored R7", 3, 1, 'h0100, 'h0003, 1);
  endtask

  task automatic t_hold;
    do_op("prep", 0, 0, 'hFF, 1, 1);
    do_op("op_valid low holds R9", 1, 0, 1, 2, 0);
    do_op("illegal opcode holds R9", 6, 0, 5, 5, 1);
  endtask

  task automatic t_ctl;
    @(negedge clk); trap_we = 1; trap_d = 1; dir_we = 1; dir_d = 1; int_set = 1;
    @(posedge clk); #1; trap_we = 0; dir_we = 0; int_set = 0;
    exp_f[8:6] = 3'b111;
    check("ctl writes R10 R11", flags_q, exp_f);
    do_op("add leaves ctl R10 R11", 0, 1, 'hFFFF, 'hFFFF, 1);
    do_op("logic leaves ctl R10 R11", 2, 0, 0, 0, 1);
    @(negedge clk); int_set = 1; int_clr = 1;
    @(posedge clk); #1; int_set = 0; int_clr = 0;
    exp_f[7] = 0;
    check("int clr wins R10", flags_q, exp_f);
    @(negedge clk); trap_we = 1; trap_d = 0;
    @(posedge clk); #1; trap_we = 0;
    exp_f[6] = 0;
    check("trap write R11", flags_q, exp_f);
    @(negedge clk); dir_d = 0;
    @(posedge clk); #1;
    check("dir needs strobe R11", flags_q, exp_f);
  endtask

  initial begin
    #(CLK_P * 2 + 2);
    t_reset;
    @(negedge clk); rst_n = 1;
    t_add;
    t_sub;
    t_logic;
    t_parity;
    t_hold;
    t_ctl;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule